// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block performs the entry into a maskable interrupt for a processor core. When a request with an 8-bit vector number is accepted, the block captures the core's current status word, program counter, stack pointers and exception base address. It then walks a fixed sequence. First it writes back a shifted status word, which drops the core into kernel mode. If the core was in user mode, it swaps the user and kernel stacks. It then records the return address and the exception status. Finally it reads the handler address from the vector table and loads it into the program counter.

All register-file updates go through a single write port, one register per cycle. The vector table is read through a simple request/response port that can stall for any number of cycles and can report an error. The block reports through a one-cycle `done` pulse whether the interrupt was taken. It is not taken if the status word had interrupts disabled or if the table read failed.

The state machine has seven named states:
- `ST_IDLE` goes to `ST_UPDATE_REGS` on an enabled request, or to `ST_DONE` on a masked one.
- `ST_UPDATE_REGS` stays for one cycle per written register and then goes to `ST_READ_VECTOR`.
- `ST_READ_VECTOR` goes to `ST_WAIT_READ`.
- `ST_WAIT_READ` goes to `ST_LOAD_PC` on a clean response, or to `ST_FAULT` on an error.
- Both `ST_LOAD_PC` and `ST_FAULT` go to `ST_DONE`.
- `ST_DONE` returns to `ST_IDLE`.

Top module: `irq_entry_seq`

## Requirements
- R1: A request accepted while the interrupt-enable bit (bit 4 of `status_in`) is 0 makes no register write, no PC write and no memory request. In the cycle after acceptance it gives `done`=1 with `taken`=0.
- R2: The first write of an enabled entry appears in the cycle after acceptance. It uses select code 0 (status) and carries ((old << 10) & 0x3FFF_FFFF) | (old & 0x8000_0000). The user-mode bit (bit 5) is therefore 0 in the written value.
- R3: If bit 5 of the captured status was 1, the status write is followed by two writes. The first uses select 1 (user stack pointer) and carries the captured `sp_in`. The second uses select 2 (stack pointer) and carries the captured `ksp_in`. In kernel mode neither register is written.
- R4: Select 3 (return register) is written with the captured `pc_in`.
- R5: Select 4 (exception status) is written with the vector times 256 (vector in bits 15:8, all else 0). Select 5 (exception data address) is written with 0.
- R6: The writes happen one per cycle in consecutive cycles, in the order status, user stack pointer, stack pointer, return register, exception status, exception data address. At most one of the write, memory request, PC write, fault and done outputs is active in any cycle.
- R7: In the cycle after the last write, `mem_req` is 1 for one cycle with `mem_addr` = captured `ebp_in` + vector × 4. The response word holds the byte at address+k in bits 8k+7:8k and forms the handler address unchanged. In the cycle after a clean response, `pc_we`=1 with that word. The next cycle gives `done`=1 with `taken`=1.
- R8: In the cycle after a response with `mem_err`=1, `fault`=1 and no PC write occurs. The next cycle gives `done`=1 with `taken`=0.
- R9: `req_ready` is 1 only in the idle state, and requests while it is 0 are ignored. `done` lasts exactly one cycle and is followed by idle. Inputs are captured at acceptance, and later changes do not affect the entry.
- R10: The block waits any number of cycles for `mem_rvalid` and produces no output activity while waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Interrupt request |
| req_vec | input | VEC_W | Vector number of the request |
| req_ready | output | 1 | Block idle, request may be accepted |
| status_in | input | DATA_W | Current status word |
| pc_in | input | DATA_W | Current program counter |
| sp_in | input | DATA_W | Current stack pointer |
| ksp_in | input | DATA_W | Kernel stack pointer value |
| ebp_in | input | DATA_W | Exception base (vector table) address |
| rf_we | output | 1 | Register write strobe |
| rf_wsel | output | 3 | Register select code (0..5) |
| rf_wdata | output | DATA_W | Register write data |
| pc_we | output | 1 | Program counter load strobe |
| pc_wdata | output | DATA_W | Handler address loaded into the PC |
| mem_req | output | 1 | Vector table read request |
| mem_addr | output | DATA_W | Vector table read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | DATA_W | Read response word |
| mem_err | input | 1 | Read response error |
| fault | output | 1 | Vector read fault pulse |
| done | output | 1 | Sequence finished pulse |
| taken | output | 1 | Interrupt taken, valid with done |

## Verification
Some behaviours are checked by the assertions on every cycle:
- a masked request ends without any work;
- the status write leads and keeps bit 31 while clearing the mode bit;
- a user stack write is always followed by the stack pointer write;
- the exception status has its fixed shape and the data-address write is zero;
- a response turns into a PC load or a fault with the right result pulse;
- at most one action is active at a time.

Other behaviours only the bench's scenarios can show, because they need the captured input values:
- the exact register values and their full order;
- the table address arithmetic, including wrap-around of the base;
- variable read latency;
- back-to-back requests held during a busy sequence;
- that input changes after acceptance are ignored.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_UPDATE_REGS = 3'd1,
        ST_READ_VECTOR = 3'd2,
        ST_WAIT_READ   = 3'd3,
        ST_LOAD_PC     = 3'd4,
        ST_FAULT       = 3'd5,
        ST_DONE        = 3'd6
    } entry_state_e;

    localparam int RF_SEL_W = 3;

    typedef enum logic [RF_SEL_W-1:0] {
        RF_STATUS = 3'd0,
        RF_USP    = 3'd1,
        RF_SP     = 3'd2,
        RF_ERP    = 3'd3,
        RF_EXS    = 3'd4,
        RF_EDA    = 3'd5
    } rf_sel_e;

    // Next register in the write order; stack registers skipped in kernel mode.
    function automatic rf_sel_e next_sel(rf_sel_e cur, logic from_user);
        rf_sel_e nxt;
        unique case (cur)
            RF_STATUS: nxt = from_user ? RF_USP : RF_ERP;
            RF_USP:    nxt = RF_SP;
            RF_SP:     nxt = RF_ERP;
            RF_ERP:    nxt = RF_EXS;
            RF_EXS:    nxt = RF_EDA;
            default:   nxt = RF_EDA;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accept,
    input  logic         int_en,
    input  logic         from_user,
    input  logic         mem_rvalid,
    input  logic         mem_err,
    output entry_state_e state,
    output rf_sel_e      sel
);

    entry_state_e state_nxt;
    rf_sel_e      sel_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel   <= RF_STATUS;
        end else begin
            state <= state_nxt;
            sel   <= sel_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        sel_nxt   = sel;
        unique case (state)
            ST_IDLE: begin
                sel_nxt = RF_STATUS;
                if (accept) begin
                    state_nxt = int_en ? ST_UPDATE_REGS : ST_DONE;
                end
            end
            ST_UPDATE_REGS: begin
                if (sel == RF_EDA) begin
                    state_nxt = ST_READ_VECTOR;
                end else begin
                    sel_nxt = next_sel(sel, from_user);
                end
            end
            ST_READ_VECTOR: state_nxt = ST_WAIT_READ;
            ST_WAIT_READ: begin
                if (mem_rvalid) begin
                    state_nxt = mem_err ? ST_FAULT : ST_LOAD_PC;
                end
            end
            ST_LOAD_PC: state_nxt = ST_DONE;
            ST_FAULT:   state_nxt = ST_DONE;
            ST_DONE:    state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/irq_status_xform.sv
module irq_status_xform #(
    parameter int DATA_W   = 32,
    parameter int SR_SHIFT = 10,
    parameter int USER_BIT = 5
) (
    input  logic [DATA_W-1:0] old_status,
    output logic [DATA_W-1:0] new_status
);

    localparam logic [DATA_W-1:0] LOW_MASK  = {2'b00, {(DATA_W-2){1'b1}}};
    localparam logic [DATA_W-1:0] KEEP_MASK = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] USER_MASK = DATA_W'(1) << USER_BIT;

    logic [DATA_W-1:0] shifted;

    always_comb begin
        shifted    = (old_status << SR_SHIFT) & LOW_MASK;
        new_status = (shifted | (old_status & KEEP_MASK)) & ~USER_MASK;
    end

endmodule

// File: rtl/irq_rf_writer.sv
module irq_rf_writer
    import irq_entry_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int VEC_W   = 8,
    parameter int EXS_POS = 8
) (
    input  logic                active,
    input  rf_sel_e             sel,
    input  logic [DATA_W-1:0]   new_status,
    input  logic [DATA_W-1:0]   cap_sp,
    input  logic [DATA_W-1:0]   cap_ksp,
    input  logic [DATA_W-1:0]   cap_pc,
    input  logic [VEC_W-1:0]    cap_vec,
    output logic                we,
    output logic [RF_SEL_W-1:0] wsel,
    output logic [DATA_W-1:0]   wdata
);

    logic [DATA_W-1:0] exs_word;

    always_comb begin
        exs_word = DATA_W'(cap_vec) << EXS_POS;
        we       = active;
        wsel     = sel;
        unique case (sel)
            RF_STATUS: wdata = new_status;
            RF_USP:    wdata = cap_sp;
            RF_SP:     wdata = cap_ksp;
            RF_ERP:    wdata = cap_pc;
            RF_EXS:    wdata = exs_word;
            default:   wdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int VEC_W     = 8,
    parameter int SR_SHIFT  = 10,
    parameter int INTEN_BIT = 4,
    parameter int USER_BIT  = 5,
    parameter int EXS_POS   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [VEC_W-1:0]    req_vec,
    output logic                req_ready,
    input  logic [DATA_W-1:0]   status_in,
    input  logic [DATA_W-1:0]   pc_in,
    input  logic [DATA_W-1:0]   sp_in,
    input  logic [DATA_W-1:0]   ksp_in,
    input  logic [DATA_W-1:0]   ebp_in,
    output logic                rf_we,
    output logic [RF_SEL_W-1:0] rf_wsel,
    output logic [DATA_W-1:0]   rf_wdata,
    output logic                pc_we,
    output logic [DATA_W-1:0]   pc_wdata,
    output logic                mem_req,
    output logic [DATA_W-1:0]   mem_addr,
    input  logic                mem_rvalid,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic                mem_err,
    output logic                fault,
    output logic                done,
    output logic                taken
);

    localparam int ADDR_SH = $clog2(DATA_W / 8);

    entry_state_e      state;
    rf_sel_e           sel;
    logic              accept;
    logic [DATA_W-1:0] cap_status, cap_pc, cap_sp, cap_ksp, cap_ebp;
    logic [VEC_W-1:0]  cap_vec;
    logic              cap_user;
    logic [DATA_W-1:0] handler_q;
    logic              taken_q;
    logic [DATA_W-1:0] new_status;

    assign accept = req_valid && (state == ST_IDLE);

    irq_entry_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .int_en     (status_in[INTEN_BIT]),
        .from_user  (cap_user),
        .mem_rvalid (mem_rvalid),
        .mem_err    (mem_err),
        .state      (state),
        .sel        (sel)
    );

    irq_status_xform #(
        .DATA_W   (DATA_W),
        .SR_SHIFT (SR_SHIFT),
        .USER_BIT (USER_BIT)
    ) u_xform (
        .old_status (cap_status),
        .new_status (new_status)
    );

    irq_rf_writer #(
        .DATA_W  (DATA_W),
        .VEC_W   (VEC_W),
        .EXS_POS (EXS_POS)
    ) u_writer (
        .active     (state == ST_UPDATE_REGS),
        .sel        (sel),
        .new_status (new_status),
        .cap_sp     (cap_sp),
        .cap_ksp    (cap_ksp),
        .cap_pc     (cap_pc),
        .cap_vec    (cap_vec),
        .we         (rf_we),
        .wsel       (rf_wsel),
        .wdata      (rf_wdata)
    );

    // Capture of the register-file view at acceptance, handler at response.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_status <= '0;
            cap_pc     <= '0;
            cap_sp     <= '0;
            cap_ksp    <= '0;
            cap_ebp    <= '0;
            cap_vec    <= '0;
            cap_user   <= 1'b0;
            handler_q  <= '0;
            taken_q    <= 1'b0;
        end else begin
            if (accept) begin
                cap_status <= status_in;
                cap_pc     <= pc_in;
                cap_sp     <= sp_in;
                cap_ksp    <= ksp_in;
                cap_ebp    <= ebp_in;
                cap_vec    <= req_vec;
                cap_user   <= status_in[USER_BIT];
                taken_q    <= 1'b0;
            end
            if (state == ST_WAIT_READ && mem_rvalid && !mem_err) begin
                handler_q <= mem_rdata;
            end
            if (state == ST_LOAD_PC) begin
                taken_q <= 1'b1;
            end
        end
    end

    assign mem_addr = cap_ebp + (DATA_W'(cap_vec) << ADDR_SH);
    assign pc_wdata = handler_q;

    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        pc_we     = 1'b0;
        fault     = 1'b0;
        done      = 1'b0;
        taken     = 1'b0;
        unique case (state)
            ST_IDLE:        req_ready = 1'b1;
            ST_UPDATE_REGS: ;
            ST_READ_VECTOR: mem_req = 1'b1;
            ST_WAIT_READ:   ;
            ST_LOAD_PC:     pc_we = 1'b1;
            ST_FAULT:       fault = 1'b1;
            ST_DONE: begin
                done  = 1'b1;
                taken = taken_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
    import irq_entry_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int VEC_W     = 8,
    parameter int INTEN_BIT = 4,
    parameter int USER_BIT  = 5,
    parameter int EXS_POS   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [DATA_W-1:0]   status_in,
    input logic                rf_we,
    input logic [RF_SEL_W-1:0] rf_wsel,
    input logic [DATA_W-1:0]   rf_wdata,
    input logic                pc_we,
    input logic [DATA_W-1:0]   pc_wdata,
    input logic                mem_req,
    input logic                mem_rvalid,
    input logic [DATA_W-1:0]   mem_rdata,
    input logic                mem_err,
    input logic                fault,
    input logic                done,
    input logic                taken
);

    logic waiting;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          waiting <= 1'b0;
        else if (mem_req)    waiting <= 1'b1;
        else if (mem_rvalid) waiting <= 1'b0;
    end

    AST_MASKED_NO_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !status_in[INTEN_BIT] |=> done && !taken && !rf_we); // R1

    AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && status_in[INTEN_BIT] |=> rf_we && rf_wsel == RF_STATUS
        && !rf_wdata[USER_BIT] && !rf_wdata[DATA_W-2]
        && rf_wdata[DATA_W-1] == $past(status_in[DATA_W-1])); // R2

    AST_USP_THEN_SP: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we && rf_wsel == RF_USP |=> rf_we && rf_wsel == RF_SP); // R3

    AST_EXS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we && rf_wsel == RF_EXS |-> rf_wdata[EXS_POS-1:0] == '0
        && (rf_wdata >> (EXS_POS + VEC_W)) == '0); // R5

    AST_EDA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we && rf_wsel == RF_EDA |-> rf_wdata == '0); // R5

    AST_EDA_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we && rf_wsel == RF_EDA |=> mem_req && !rf_we); // R7

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, mem_req, pc_we, fault, done})); // R6

    AST_GOOD_LOADS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && mem_rvalid && !mem_err |=> pc_we && pc_wdata == $past(mem_rdata)); // R7

    AST_ERR_NO_PC: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && mem_rvalid && mem_err |=> fault && !pc_we); // R8

    AST_FAULT_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> done && !taken); // R8

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rf_we && !pc_we && !mem_req && !fault && !done); // R9

    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && !mem_rvalid |-> !rf_we && !pc_we && !fault && !done && !req_ready); // R10

endmodule

bind irq_entry_seq irq_entry_chk #(
    .DATA_W    (DATA_W),
    .VEC_W     (VEC_W),
    .INTEN_BIT (INTEN_BIT),
    .USER_BIT  (USER_BIT),
    .EXS_POS   (EXS_POS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .status_in  (status_in),
    .rf_we      (rf_we),
    .rf_wsel    (rf_wsel),
    .rf_wdata   (rf_wdata),
    .pc_we      (pc_we),
    .pc_wdata   (pc_wdata),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .mem_err    (mem_err),
    .fault      (fault),
    .done       (done),
    .taken      (taken)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vec = '0;
    logic        req_ready;
    logic [31:0] status_in = '0, pc_in = '0, sp_in = '0, ksp_in = '0, ebp_in = '0;
    logic        rf_we;
    logic [2:0]  rf_wsel;
    logic [31:0] rf_wdata;
    logic        pc_we;
    logic [31:0] pc_wdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        fault, done, taken;

    always #4 clk = ~clk;   // 125 MHz

    irq_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
        .req_ready(req_ready), .status_in(status_in), .pc_in(pc_in), .sp_in(sp_in),
        .ksp_in(ksp_in), .ebp_in(ebp_in), .rf_we(rf_we), .rf_wsel(rf_wsel),
        .rf_wdata(rf_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .fault(fault), .done(done), .taken(taken)
    );

    typedef struct {
        bit        ready;
        bit        we;
        bit [2:0]  sel;
        bit [31:0] wdata;
        bit        mreq;
        bit [31:0] addr;
        bit        pwe;
        bit [31:0] pdata;
        bit        flt;
        bit        dn;
        bit        tk;
        string     tag;
    } exp_t;

    exp_t expq[$];
    int   total = 0;
    int   bad = 0;
    int   lat = 1;
    bit   err_next = 1'b0;
    bit   run_chk = 1'b0;
    int   rcnt = 0;
    logic [31:0] raddr = '0;
    logic [31:0] seed = 32'h1234_5677;

    function automatic exp_t blank(string tag);
        exp_t r;
        r.ready = 0; r.we = 0; r.sel = 0; r.wdata = 0; r.mreq = 0; r.addr = 0;
        r.pwe = 0; r.pdata = 0; r.flt = 0; r.dn = 0; r.tk = 0; r.tag = tag;
        return r;
    endfunction

    function automatic logic [7:0] mem_byte(logic [31:0] a);
        return 8'(a * 7 + 32'h3D) ^ a[15:8];
    endfunction

    // Little-endian word: byte at address+k lands in bits 8k+7:8k.
    function automatic logic [31:0] mem_word(logic [31:0] a);
        return {mem_byte(a + 3), mem_byte(a + 2), mem_byte(a + 1), mem_byte(a)};
    endfunction

    function automatic void check(bit ok, string tag, string what,
                                  logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endfunction

    function automatic void build(logic [31:0] st, logic [31:0] pc, logic [31:0] sp,
                                  logic [31:0] ksp, logic [31:0] ebp, logic [7:0] vec,
                                  int l, bit e);
        exp_t r;
        logic [31:0] a;
        if (!st[4]) begin
            r = blank("R1"); r.dn = 1; r.tk = 0; expq.push_back(r);
            return;
        end
        r = blank("R2"); r.we = 1; r.sel = 0;
        r.wdata = (((st << 10) & 32'h3FFF_FFFF) | (st & 32'h8000_0000)) & ~32'h20;
        expq.push_back(r);
        if (st[5]) begin
            r = blank("R3"); r.we = 1; r.sel = 1; r.wdata = sp;  expq.push_back(r);
            r = blank("R3"); r.we = 1; r.sel = 2; r.wdata = ksp; expq.push_back(r);
        end
        r = blank("R4"); r.we = 1; r.sel = 3; r.wdata = pc;              expq.push_back(r);
        r = blank("R5"); r.we = 1; r.sel = 4; r.wdata = {16'h0, vec, 8'h0}; expq.push_back(r);
        r = blank("R5"); r.we = 1; r.sel = 5; r.wdata = 0;               expq.push_back(r);
        a = ebp + {22'h0, vec, 2'b00};
        r = blank("R7"); r.mreq = 1; r.addr = a; expq.push_back(r);
        for (int i = 0; i < l; i++) expq.push_back(blank("R10"));
        if (e) begin
            r = blank("R8"); r.flt = 1; expq.push_back(r);
            r = blank("R8"); r.dn = 1; r.tk = 0; expq.push_back(r);
        end else begin
            r = blank("R7"); r.pwe = 1; r.pdata = mem_word(a); expq.push_back(r);
            r = blank("R7"); r.dn = 1; r.tk = 1; expq.push_back(r);
        end
    endfunction

    // Reference comparison, once per cycle away from the active edge.
    always @(negedge clk) begin
        if (run_chk) begin
            exp_t r;
            if (expq.size() > 0) r = expq.pop_front();
            else begin r = blank("R9"); r.ready = 1; end
            check(req_ready == r.ready, r.tag, "req_ready", 32'(req_ready), 32'(r.ready));
            check(rf_we == r.we, r.tag, "rf_we", 32'(rf_we), 32'(r.we));
            if (r.we) begin
                check(rf_wsel == r.sel, "R6", "rf_wsel", 32'(rf_wsel), 32'(r.sel));
                check(rf_wdata == r.wdata, r.tag, "rf_wdata", rf_wdata, r.wdata);
            end
            check(mem_req == r.mreq, r.tag, "mem_req", 32'(mem_req), 32'(r.mreq));
            if (r.mreq) check(mem_addr == r.addr, r.tag, "mem_addr", mem_addr, r.addr);
            check(pc_we == r.pwe, r.tag, "pc_we", 32'(pc_we), 32'(r.pwe));
            if (r.pwe) check(pc_wdata == r.pdata, r.tag, "pc_wdata", pc_wdata, r.pdata);
            check(fault == r.flt, r.tag, "fault", 32'(fault), 32'(r.flt));
            check(done == r.dn, r.tag, "done", 32'(done), 32'(r.dn));
            if (r.dn) check(taken == r.tk, r.tag, "taken", 32'(taken), 32'(r.tk));
            if (r.ready && req_valid)
                build(status_in, pc_in, sp_in, ksp_in, ebp_in, req_vec, lat, err_next);
        end
    end

    // Vector table memory with bench-chosen latency and error.
    always @(posedge clk) begin
        #1;
        if (mem_req) begin
            rcnt = lat; raddr = mem_addr; mem_rvalid = 1'b0; mem_err = 1'b0;
        end else if (rcnt > 0) begin
            rcnt--;
            if (rcnt == 0) begin
                mem_rvalid = 1'b1; mem_err = err_next; mem_rdata = mem_word(raddr);
            end
        end else begin
            mem_rvalid = 1'b0; mem_err = 1'b0; mem_rdata = 32'hDEAD_0BAD;
        end
    end

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic wait_idle();
        @(posedge clk);
        while (expq.size() != 0 || !req_ready) @(posedge clk);
    endtask

    task automatic entry(logic [31:0] st, logic [31:0] pc, logic [31:0] sp,
                         logic [31:0] ksp, logic [31:0] ebp, logic [7:0] vec, int l, bit e);
        @(posedge clk); #1;
        status_in = st; pc_in = pc; sp_in = sp; ksp_in = ksp; ebp_in = ebp;
        req_vec = vec; lat = l; err_next = e; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        // R9: scrambled inputs after acceptance must not affect the entry
        status_in = ~st & ~32'h10; pc_in = ~pc; sp_in = ~sp; ksp_in = ~ksp;
        ebp_in = ~ebp; req_vec = ~vec;
        wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R9 watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state: idle and quiet
        check(req_ready == 1'b1, "R9", "reset req_ready", 32'(req_ready), 32'h1);
        check({rf_we, pc_we, mem_req, fault, done} == 5'b0, "R9", "reset outputs",
              32'({rf_we, pc_we, mem_req, fault, done}), 32'h0);
        run_chk = 1'b1;

        // R1: masked request (enable bit 4 clear), user bit set
        entry(32'h0000_0020, 32'h1000, 32'h2000, 32'h3000, 32'h4000, 8'h11, 1, 0);
        // R2 R4 R5 R7: kernel mode, immediate response
        entry(32'h0000_0010, 32'h0800_0100, 32'h7000, 32'h9000, 32'h0001_0000, 8'h10, 1, 0);
        // R3 R10: user mode, top vector, slow response
        entry(32'h0000_0030, 32'hCAFE_0000, 32'h5555_AAA0, 32'h8000_1000, 32'h0002_0000, 8'hFF, 3, 0);
        // R8: user mode, table read error
        entry(32'h0000_0033, 32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h0000_8000, 8'h42, 2, 1);
        // R2: bit 31 kept, bit 30 dropped, truncation of high bits
        entry(32'hFFFF_FFDF, 32'h0, 32'h0, 32'h0, 32'h0, 8'h00, 1, 0);
        entry(32'h7C00_0FFF, 32'h0, 32'h1, 32'h2, 32'h10, 8'h01, 1, 0);
        // R7: base near top wraps around
        entry(32'h0000_0010, 32'h4, 32'h8, 32'hC, 32'hFFFF_FFF0, 8'hFF, 5, 0);
        // R8 in kernel mode with long wait (R10)
        entry(32'h0000_0010, 32'hABCD_0000, 32'h0, 32'h0, 32'h100, 8'h07, 9, 1);

        // R9: request held high through a busy entry, taken again only when idle
        @(posedge clk); #1;
        status_in = 32'h0000_0010; pc_in = 32'h600; sp_in = 32'h700; ksp_in = 32'h800;
        ebp_in = 32'h2000; req_vec = 8'h21; lat = 2; err_next = 0; req_valid = 1'b1;
        repeat (14) @(posedge clk);
        #1 req_valid = 1'b0;
        wait_idle();

        // Mixed patterns
        for (int n = 0; n < 24; n++) begin
            logic [31:0] s;
            s = rnd();
            entry(s, rnd(), rnd(), rnd(), rnd(), 8'(rnd()), 1 + int'(rnd() % 6), rnd() % 5 == 0);
        end

        repeat (3) @(posedge clk);
        check(expq.size() == 0, "R9", "trace drained", 32'(expq.size()), 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule